// File: doc/BRIEF.md
# Fault-Aware Redundant Enable Configuration Register

This block holds a small configuration word made of three 4-bit enable fields. Each field carries a redundant boolean: one 4-bit code means "on", a second code means "off", and every other value is a fault. The block turns each field into a single-bit enable. An invalid code yields a disabled output. Two of the three enables also need an 8-bit permission input, burned in at manufacture, to carry its own "on" code.

A one-way lock bit guards the configuration word. The lock starts open. Software can close it by writing 0, and after that the word no longer accepts writes until the next reset. A three-bit fault status word has one sticky bit per field. A bit sets when its field holds an invalid code, and software clears it by writing 0. Each time a status bit goes from clear to set, a recoverable-alert output pulses for one cycle. Address decoding, the alert handshake and the logic that uses the enables live outside this block.

Top module: `mb_cfg_reg`

## Requirements
- R1: After a synchronous active-low reset, the configuration word reads 12'h999 (all fields off), the lock reads 1, the status word reads 0, all enables read 0 and the alert output reads 0.
- R2: While the lock is 1, a write strobe on the configuration word loads the write data. The new value is visible on the clock edge that samples the strobe.
- R3: Writing 0 to the lock clears it. Writing 1 never sets it again; only reset reopens it. A configuration write in the same cycle as the lock clear is still accepted.
- R4: While the lock is 0, configuration writes are ignored and the word keeps its value.
- R5: Field codes: 4'h6 means on and 4'h9 means off. en_o[0] follows bits 3:0 and is 1 only when that field is 4'h6. Any other code gives 0.
- R6: en_o[1] follows bits 7:4 and en_o[2] follows bits 11:8. Each is 1 only when its field is 4'h6 and perm_i equals 8'h96. en_o[0] does not depend on perm_i.
- R7: When a field holds a code other than 4'h6 or 4'h9, its status bit is set on the next clock edge and stays set. The mapping is bit 0 for bits 3:0, bit 1 for bits 7:4 and bit 2 for bits 11:8.
- R8: A status write clears each bit whose write-data bit is 0 and leaves bits written with 1 unchanged. A clear takes priority in its own cycle. If the field is still invalid, the bit sets again one cycle later.
- R9: alert_o is 1 in exactly the cycles in which some status bit is 1 that was 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Configuration word write strobe |
| ctrl_wdata | input | 12 | Configuration write data |
| lock_we | input | 1 | Lock write strobe |
| lock_wdata | input | 1 | Lock write data (0 closes the lock) |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Status write data (0 clears a bit) |
| perm_i | input | 8 | Manufacture-time permission code |
| ctrl_q | output | 12 | Configuration word readback |
| lock_q | output | 1 | Lock readback |
| sts_q | output | 3 | Fault status readback |
| en_o | output | 3 | Decoded enables |
| alert_o | output | 1 | One-cycle recoverable alert pulse |

## Verification
A wrong stored configuration shows up on ctrl_q and en_o on the first edge after the write. A bad lock state shows up the first time a write that should be frozen changes ctrl_q, or a write that should land is dropped. Errors in the fault tracking show on sts_q one edge after an invalid code arrives, and on alert_o in that same cycle. Clear-then-reset behaviour is observed over two consecutive cycles. The permission gating is checked combinationally against perm_i with the stored word held fixed.

// File: rtl/mb_cfg_pkg.sv
// Shared encodings for the redundant-enable configuration register.
// Assumes 4-bit field codes and an 8-bit permission code.
package mb_cfg_pkg;
    localparam int unsigned FIELD_W_DEF = 4;
    localparam int unsigned PERM_W_DEF  = 8;
    localparam logic [FIELD_W_DEF-1:0] CODE_ON_DEF  = 4'h6;
    localparam logic [FIELD_W_DEF-1:0] CODE_OFF_DEF = 4'h9;
    localparam logic [PERM_W_DEF-1:0]  PERM_ON_DEF  = 8'h96;
endpackage

// File: rtl/mb_field_decode.sv
// Decodes one redundant boolean field into an enable and a fault flag.
// Assumes the permission compare is done once by the caller (perm_ok).
module mb_field_decode #(
    parameter int unsigned          FIELD_W  = 4,
    parameter logic [FIELD_W-1:0]   CODE_ON  = 4'h6,
    parameter logic [FIELD_W-1:0]   CODE_OFF = 4'h9,
    parameter bit                   GATED    = 1'b0
) (
    input  logic [FIELD_W-1:0] field_i,
    input  logic               perm_ok_i,
    output logic               en_o,
    output logic               bad_o
);
    logic is_on;
    logic is_off;

    // Classify the field code and form the enable.
    always_comb begin
        is_on  = (field_i == CODE_ON);
        is_off = (field_i == CODE_OFF);
        bad_o  = !(is_on || is_off);
        if (GATED) begin
            en_o = is_on && perm_ok_i;
        end else begin
            en_o = is_on;
        end
    end
endmodule

// File: rtl/mb_cfg_lock.sv
// One-way lock: resets open (1), a write of 0 closes it until next reset.
// Assumes synchronous active-low reset.
module mb_cfg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic wdata_i,
    output logic lock_q
);
    // Hold the lock; only a zero write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
        end else if (we_i && !wdata_i) begin
            lock_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mb_alert_sts.sv
// Sticky fault status with write-zero-to-clear and a rising-bit alert pulse.
// Assumes bad_i is the current fault flag of each field; clear beats set.
module mb_alert_sts #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] bad_i,
    input  logic         we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] sts_q,
    output logic         alert_o
);
    logic [N-1:0] sts_d;
    logic [N-1:0] clr;

    // Work out the next status value, one bit per field.
    always_comb begin
        clr = we_i ? ~wdata_i : '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Clear has priority; otherwise a fault sets, else hold.
        always_comb begin
            if (clr[i]) begin
                sts_d[i] = 1'b0;
            end else if (bad_i[i]) begin
                sts_d[i] = 1'b1;
            end else begin
                sts_d[i] = sts_q[i];
            end
        end
    end

    // Register status and the alert for any newly set bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q   <= '0;
            alert_o <= 1'b0;
        end else begin
            sts_q   <= sts_d;
            alert_o <= |(sts_d & ~sts_q);
        end
    end
endmodule

// File: rtl/mb_cfg_reg.sv
// Top: lockable configuration word of redundant boolean fields, decoded
// enables gated by a permission code, and per-field fault status.
// Assumes field i occupies bits [i*FIELD_W +: FIELD_W].
module mb_cfg_reg #(
    parameter int unsigned                  NUM_FIELDS = 3,
    parameter int unsigned                  FIELD_W    = mb_cfg_pkg::FIELD_W_DEF,
    parameter int unsigned                  PERM_W     = mb_cfg_pkg::PERM_W_DEF,
    parameter logic [FIELD_W-1:0]           CODE_ON    = mb_cfg_pkg::CODE_ON_DEF,
    parameter logic [FIELD_W-1:0]           CODE_OFF   = mb_cfg_pkg::CODE_OFF_DEF,
    parameter logic [PERM_W-1:0]            PERM_ON    = mb_cfg_pkg::PERM_ON_DEF,
    parameter logic [NUM_FIELDS-1:0]        GATE_MASK  = 3'b110,
    localparam int unsigned                 CTRL_W     = NUM_FIELDS * FIELD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic [CTRL_W-1:0]     ctrl_wdata,
    input  logic                  lock_we,
    input  logic                  lock_wdata,
    input  logic                  sts_we,
    input  logic [NUM_FIELDS-1:0] sts_wdata,
    input  logic [PERM_W-1:0]     perm_i,
    output logic [CTRL_W-1:0]     ctrl_q,
    output logic                  lock_q,
    output logic [NUM_FIELDS-1:0] sts_q,
    output logic [NUM_FIELDS-1:0] en_o,
    output logic                  alert_o
);
    localparam logic [CTRL_W-1:0] CTRL_RST = {NUM_FIELDS{CODE_OFF}};

    logic                  perm_ok;
    logic [NUM_FIELDS-1:0] bad;

    // Single compare of the permission code, shared by gated fields.
    always_comb begin
        perm_ok = (perm_i == PERM_ON);
    end

    // Lock bit guarding the configuration word.
    mb_cfg_lock i_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lock_we),
        .wdata_i (lock_wdata),
        .lock_q  (lock_q)
    );

    // Configuration storage, written only while the lock is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_we && lock_q) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        mb_field_decode #(
            .FIELD_W  (FIELD_W),
            .CODE_ON  (CODE_ON),
            .CODE_OFF (CODE_OFF),
            .GATED    (GATE_MASK[f])
        ) i_dec (
            .field_i   (ctrl_q[f*FIELD_W +: FIELD_W]),
            .perm_ok_i (perm_ok),
            .en_o      (en_o[f]),
            .bad_o     (bad[f])
        );
    end

    // Sticky fault status and alert pulse.
    mb_alert_sts #(
        .N (NUM_FIELDS)
    ) i_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .bad_i   (bad),
        .we_i    (sts_we),
        .wdata_i (sts_wdata),
        .sts_q   (sts_q),
        .alert_o (alert_o)
    );
endmodule

// File: rtl/mb_cfg_reg_chk.sv
// Checker for mb_cfg_reg, bound to every instance of the top.
module mb_cfg_reg_chk #(
    parameter int unsigned           NUM_FIELDS = 3,
    parameter int unsigned           FIELD_W    = 4,
    parameter int unsigned           PERM_W     = 8,
    parameter logic [FIELD_W-1:0]    CODE_ON    = 4'h6,
    parameter logic [FIELD_W-1:0]    CODE_OFF   = 4'h9,
    parameter logic [PERM_W-1:0]     PERM_ON    = 8'h96,
    parameter logic [NUM_FIELDS-1:0] GATE_MASK  = 3'b110,
    localparam int unsigned          CTRL_W     = NUM_FIELDS * FIELD_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctrl_we,
    input logic [CTRL_W-1:0]     ctrl_wdata,
    input logic                  sts_we,
    input logic [NUM_FIELDS-1:0] sts_wdata,
    input logic [PERM_W-1:0]     perm_i,
    input logic [CTRL_W-1:0]     ctrl_q,
    input logic                  lock_q,
    input logic [NUM_FIELDS-1:0] sts_q,
    input logic [NUM_FIELDS-1:0] en_o,
    input logic                  alert_o
);
    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && lock_q) |=> (ctrl_q == $past(ctrl_wdata)));

    // R3
    lock_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> !lock_q);

    // R4
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q |=> $stable(ctrl_q));

    // R5
    core_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o[0] |-> (ctrl_q[FIELD_W-1:0] == CODE_ON));

    // R6
    perm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_i != PERM_ON) |-> ((en_o & GATE_MASK) == '0));

    // R9
    alert_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o == (|(sts_q & ~$past(sts_q))));

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_chk
        logic fbad;
        always_comb begin
            fbad = (ctrl_q[i*FIELD_W +: FIELD_W] != CODE_ON) &&
                   (ctrl_q[i*FIELD_W +: FIELD_W] != CODE_OFF);
        end
        // R7
        sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fbad && !(sts_we && !sts_wdata[i])) |=> sts_q[i]);
        // R8
        sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_we && !sts_wdata[i]) |=> !sts_q[i]);
    end
endmodule

bind mb_cfg_reg mb_cfg_reg_chk #(
    .NUM_FIELDS (NUM_FIELDS),
    .FIELD_W    (FIELD_W),
    .PERM_W     (PERM_W),
    .CODE_ON    (CODE_ON),
    .CODE_OFF   (CODE_OFF),
    .PERM_ON    (PERM_ON),
    .GATE_MASK  (GATE_MASK)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .sts_we     (sts_we),
    .sts_wdata  (sts_wdata),
    .perm_i     (perm_i),
    .ctrl_q     (ctrl_q),
    .lock_q     (lock_q),
    .sts_q      (sts_q),
    .en_o       (en_o),
    .alert_o    (alert_o)
);

// File: tb/test_mb_cfg_reg.sv
module test_mb_cfg_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [11:0] ctrl_wdata = '0;
    logic        lock_we = 1'b0;
    logic        lock_wdata = 1'b0;
    logic        sts_we = 1'b0;
    logic [2:0]  sts_wdata = '0;
    logic [7:0]  perm_i = 8'h96;
    logic [11:0] ctrl_q;
    logic        lock_q;
    logic [2:0]  sts_q;
    logic [2:0]  en_o;
    logic        alert_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mb_cfg_reg i_mb_cfg_reg (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .lock_we(lock_we), .lock_wdata(lock_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .perm_i(perm_i),
        .ctrl_q(ctrl_q), .lock_q(lock_q), .sts_q(sts_q),
        .en_o(en_o), .alert_o(alert_o)
    );

    // {ctrl word[25:14], perm[13:6], expected en[5:3], expected status[2:0]}
    localparam logic [25:0] VEC [14] = '{
        {12'h999, 8'h96, 3'b000, 3'b000},
        {12'h996, 8'h96, 3'b001, 3'b000},
        {12'h966, 8'h96, 3'b011, 3'b000},
        {12'h666, 8'h96, 3'b111, 3'b000},
        {12'h666, 8'h69, 3'b001, 3'b000},
        {12'h666, 8'h00, 3'b001, 3'b000},
        {12'h696, 8'h96, 3'b101, 3'b000},
        {12'h660, 8'h96, 3'b110, 3'b001},
        {12'h6F6, 8'h96, 3'b101, 3'b010},
        {12'h596, 8'h96, 3'b001, 3'b100},
        {12'h000, 8'h96, 3'b000, 3'b111},
        {12'h669, 8'h96, 3'b110, 3'b000},
        {12'h666, 8'h97, 3'b001, 3'b000},
        {12'h9A9, 8'h96, 3'b000, 3'b010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cyc();
        // R1 reset state
        check("R1 ctrl", ctrl_q, 12'h999);
        check("R1 lock", lock_q, 1);
        check("R1 sts", sts_q, 0);
        check("R1 en", en_o, 0);
        check("R1 alert", alert_o, 0);
        rst_n = 1'b1;
        cyc();

        for (int v = 0; v < 14; v++) begin
            perm_i = VEC[v][13:6];
            ctrl_we = 1'b1; ctrl_wdata = VEC[v][25:14];
            cyc();
            ctrl_we = 1'b0; sts_we = 1'b1; sts_wdata = 3'b000;
            cyc();
            sts_we = 1'b0;
            cyc();
            check("R2 ctrl load", ctrl_q, VEC[v][25:14]);
            check("R5/R6 enables", en_o, VEC[v][5:3]);
            check("R7 status", sts_q, VEC[v][2:0]);
            check("R9 alert", alert_o, VEC[v][2:0] != 0);
        end

        // last vector left bits 7:4 invalid, status 010
        cyc();
        check("R9 alert one cycle", alert_o, 0);
        check("R7 sticky", sts_q, 3'b010);
        sts_we = 1'b1; sts_wdata = 3'b111;
        cyc();
        sts_we = 1'b0;
        check("R8 write one keeps", sts_q, 3'b010);
        check("R9 no alert on hold", alert_o, 0);
        sts_we = 1'b1; sts_wdata = 3'b101;
        cyc();
        sts_we = 1'b0;
        check("R8 clear wins", sts_q, 3'b000);
        cyc();
        check("R8 resets while bad", sts_q, 3'b010);
        check("R9 alert again", alert_o, 1);

        // R3/R4 lock behaviour
        lock_we = 1'b1; lock_wdata = 1'b1;
        cyc();
        check("R3 write one no effect", lock_q, 1);
        lock_wdata = 1'b0; ctrl_we = 1'b1; ctrl_wdata = 12'h666;
        cyc();
        lock_we = 1'b0; ctrl_we = 1'b0;
        check("R3 lock cleared", lock_q, 0);
        check("R3 same-cycle write taken", ctrl_q, 12'h666);
        ctrl_we = 1'b1; ctrl_wdata = 12'h999;
        cyc();
        ctrl_we = 1'b0;
        check("R4 ctrl frozen", ctrl_q, 12'h666);
        check("R4 enables kept", en_o, 3'b111);
        perm_i = 8'h00;
        #1;
        check("R6 perm gate live", en_o, 3'b001);
        lock_we = 1'b1; lock_wdata = 1'b1;
        cyc();
        lock_we = 1'b0;
        check("R3 cannot reopen", lock_q, 0);

        // R1 reset reopens everything
        rst_n = 1'b0;
        cyc();
        check("R1 reset ctrl", ctrl_q, 12'h999);
        check("R1 reset lock", lock_q, 1);
        check("R1 reset sts", sts_q, 0);
        check("R1 reset alert", alert_o, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule